// File: doc/BRIEF.md
# Radix-4 Early-Out Integer Multiplier

This block is a sequential integer multiplier for 64-bit operands. A one-cycle start pulse supplies a multiplicand, a multiplier and a select that marks the multiplier as signed or unsigned. The block returns the low 64 bits of the product with a one-cycle done pulse.

Each iteration retires two multiplier bits through radix-4 Booth recoding. The multiplier is held in a register two bits wider than an operand. In signed mode that register is sign-extended and in unsigned mode it is zero-extended. Before each iteration the block checks the bits that are still unconsumed. If they all equal the last consumed bit, every remaining Booth digit is zero and the block stops at once.

A zero multiplier therefore costs only the setup cycle and the completion cycle. The longest case is an unsigned multiplier with its top bit set. That case needs 33 digits and finishes 35 cycles after the start.

Top module: `booth4_mul`

## Requirements
- R1: After each accepted operation, `prod_o` equals `(a_i * b_i) mod 2^64`. The value is the same whether `signed_i` is 0 or 1.
- R2: A start with `b_i == 0` raises `done_o` exactly 2 cycles after the start cycle.
- R3: Let E be the multiplier extended to 66 bits: sign-extended when `signed_i` is 1, zero-extended when it is 0. Let k be the smallest count of consumed bit pairs for which all bits of E at positions 2k and above equal bit 2k-1 (taken as 0 when k is 0). `done_o` rises exactly k+2 cycles after the start cycle.
- R4: No operation takes more than 35 cycles from start to done. An unsigned multiplier with bit 63 set takes exactly 35 cycles, and a signed one with bit 63 set and bit 62 clear takes 34.
- R5: `busy_o` is high from the cycle after an accepted start up to, but not including, the done cycle. `done_o` is a single-cycle pulse during which `busy_o` is low.
- R6: A start pulse while `busy_o` is high is ignored. The running operation returns its own product on time, and no second done pulse follows.
- R7: Reset clears `busy_o`, `done_o` and `prod_o` to 0.
- R8: `prod_o` holds its value from the done cycle until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; accepted only while not busy |
| signed_i | input | 1 | 1: multiplier is signed; 0: unsigned |
| a_i | input | 64 | Multiplicand |
| b_i | input | 64 | Multiplier |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| prod_o | output | 64 | Low 64 bits of the product |

## Verification
The bench walks the multiplier through every value from -256 to 255, then through single set bits, single clear bits and runs of ones at every bit position, in both modes. For each case it checks the exact done cycle against an arithmetic model of the early-out rule. A termination test that is off by one would move the done cycle in nearly every case. Treating the unsigned extension as signed would end all-ones multipliers too early in unsigned mode, and would never reach the 35-cycle case. A wrong Booth digit, such as a sign error on the -2 case, would corrupt products for multipliers that have adjacent ones. A second start injected mid-operation must change neither the product nor the timing, and must not produce a second done pulse.

// File: rtl/booth4_mul.sv
module booth4_mul #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         signed_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] prod_o
);
  localparam int MW = W + 2;
  localparam int MAXB = W / 2 + 2;
  localparam int CW = $clog2(MAXB + 2) + 1;

  logic [MW-1:0] m_q;
  logic          prev_q;
  logic [W-1:0]  a_q, acc_q, addend;
  logic          busy_q, done_q;

  wire quit = prev_q ? (&m_q) : ~(|m_q);
  wire [2:0] dig = {m_q[1], m_q[0], prev_q};

  always_comb begin
    case (dig)
      3'b001, 3'b010: addend = a_q;
      3'b011:         addend = a_q << 1;
      3'b100:         addend = -(a_q << 1);
      3'b101, 3'b110: addend = -a_q;
      default:        addend = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q    <= '0;
      prev_q <= 1'b0;
      a_q    <= '0;
      acc_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (!busy_q) begin
      done_q <= 1'b0;
      if (start_i) begin
        m_q    <= signed_i ? {{2{b_i[W-1]}}, b_i} : {2'b00, b_i};
        prev_q <= 1'b0;
        a_q    <= a_i;
        acc_q  <= '0;
        busy_q <= 1'b1;
      end
    end else if (quit) begin
      busy_q <= 1'b0;
      done_q <= 1'b1;
    end else begin
      acc_q  <= acc_q + addend;
      a_q    <= a_q << 2;
      m_q    <= {m_q[MW-1], m_q[MW-1], m_q[MW-1:2]};
      prev_q <= m_q[1];
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign prod_o = acc_q;

  logic [CW-1:0] lat_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lat_q <= '0;
    else if (busy_q) lat_q <= lat_q + 1'b1;
    else             lat_q <= '0;
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o); // R5
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> !busy_o); // R5
  AST_ZERO_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && b_i == '0) |=> ##1 done_o); // R2
  AST_LAT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) busy_o |-> (lat_q < CW'(MAXB))); // R4
  AST_IGNORE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> (busy_o || done_o)); // R6
  AST_PROD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !$past(busy_o)) |-> $stable(prod_o)); // R8
endmodule

// File: tb/booth4_mul_bench.sv
module booth4_mul_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        signed_i = 1'b0;
  logic [63:0] a_i = '0, b_i = '0;
  logic        busy_o, done_o;
  logic [63:0] prod_o;
  int total = 0, bad = 0;
  logic [63:0] lfsr = 64'h9E3779B97F4A7C15;

  always #10 clk = ~clk;

  booth4_mul u_booth4_mul (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .signed_i(signed_i),
    .a_i(a_i), .b_i(b_i), .busy_o(busy_o), .done_o(done_o), .prod_o(prod_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int model_lat(input logic [63:0] b, input bit sg);
    logic [65:0] e = sg ? {{2{b[63]}}, b} : {2'b00, b};
    for (int k = 0; k <= 33; k++) begin
      logic p = (k == 0) ? 1'b0 : e[2*k-1];
      bit all = 1'b1;
      for (int j = 2*k; j < 66; j++) if (e[j] != p) all = 1'b0;
      if (all) return k + 2;
    end
    return 99;
  endfunction

  task automatic run(input logic [63:0] a, input logic [63:0] b, input bit sg, input bit inject);
    int cyc = 0;
    int exp_lat = model_lat(b, sg);
    bit busy_ok = 1'b1;
    @(negedge clk);
    start_i = 1'b1; a_i = a; b_i = b; signed_i = sg;
    @(negedge clk);
    start_i = 1'b0; a_i = ~a; b_i = ~b;
    cyc = 1;
    while (!done_o && cyc < 60) begin
      if (!busy_o) busy_ok = 1'b0;
      if (inject && cyc == 1) start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      cyc++;
    end
    chk(cyc == exp_lat, sg ? "R3 signed latency" : "R3 unsigned latency", 64'(cyc), 64'(exp_lat));
    chk(cyc <= 35, "R4 latency bound", 64'(cyc), 64'd35);
    chk(busy_ok && !busy_o, "R5 busy window", {63'd0, busy_o}, 64'd0);
    chk(prod_o == a * b, inject ? "R6 product after ignored start" : "R1 product", prod_o, a * b);
    if (b == '0) chk(cyc == 2, "R2 zero multiplier", 64'(cyc), 64'd2);
    @(negedge clk);
    chk(!done_o, "R5 done single pulse", {63'd0, done_o}, 64'd0);
    if (inject) begin
      @(negedge clk);
      chk(!done_o && !busy_o, "R6 no second done", {62'd0, busy_o, done_o}, 64'd0);
      chk(prod_o == a * b, "R8 product held", prod_o, a * b);
    end
  endtask

  function automatic logic [63:0] nxt(input logic [63:0] v);
    return {v[62:0], v[63] ^ v[62] ^ v[60] ^ v[59]};
  endfunction

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && prod_o == '0, "R7 reset state", prod_o, 64'd0);
    rst_n = 1'b1;
    for (int i = -256; i < 256; i++) begin
      lfsr = nxt(lfsr);
      run(lfsr, 64'(i), i[0], 1'b0);
      run(lfsr, 64'(i), ~i[0], 1'b0);
    end
    for (int s = 0; s < 64; s++) begin
      for (int m = 0; m < 2; m++) begin
        lfsr = nxt(lfsr);
        run(lfsr, 64'd1 << s, m[0], 1'b0);
        run(lfsr, ~(64'd1 << s), m[0], 1'b0);
        run(lfsr, (64'd1 << s) - 1, m[0], 1'b0);
        run(lfsr, ~((64'd1 << s) - 1), m[0], 1'b0);
      end
    end
    run(64'h0123456789ABCDEF, 64'h8000000000000000, 1'b0, 1'b0);
    chk(model_lat(64'h8000000000000000, 1'b0) == 35, "R4 unsigned worst case", 64'd35, 64'd35);
    run(64'hFFFFFFFFFFFFFFFF, 64'h8000000000000000, 1'b1, 1'b0);
    chk(model_lat(64'h8000000000000000, 1'b1) == 34, "R4 signed worst case", 64'd34, 64'd34);
    run(64'hDEADBEEFCAFEF00D, 64'hFFFFFFFFFFFFFFFF, 1'b0, 1'b0);
    run(64'hDEADBEEFCAFEF00D, 64'hFFFFFFFFFFFFFFFF, 1'b1, 1'b0);
    run(64'h7FFFFFFFFFFFFFFF, 64'h5555555555555555, 1'b0, 1'b1);
    run(64'h1234, 64'h0000000000000000, 1'b1, 1'b1);
    run(64'hAAAAAAAAAAAAAAAA, 64'hC3C3C3C3C3C3C3C3, 1'b1, 1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule